// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This peripheral keeps time as a plain 32-bit count of seconds. A slow oscillator, nominally 32.768 kHz, reaches the block as a one-cycle enable pulse `slow_en` in the bus clock domain. A programmable prescaler turns those pulses into a once-per-second tick. Each tick adds one to the seconds counter. When the new count equals a programmed alarm value, the tick also raises an alarm event.

The prescaler configuration word holds a divide value in its low half and a signed trim in its upper half. Once in every 1024 seconds, the trim lengthens or shortens that one second, which corrects a slow or fast crystal. A configuration word of zero, which is the reset value, falls back to a divide by 32768, so the clock keeps running even when nobody has programmed it.

Software reaches the block through a small register bus. The status register holds two sticky event flags that are cleared by writing a one to them. It also holds two ordinary enable bits, each two positions above the flag it gates, and these drive the two interrupt lines. A parameter selects between two address layouts.

Top module: `srtc_top`

## Requirements
- R1: After reset, the seconds, alarm, configuration and status registers all read zero, and `irq_alarm` and `irq_tick` are low.
- R2: In the default layout the alarm value is at 0x00, the seconds counter at 0x04, the configuration at 0x08 and the status at 0x10. The first three read back any 32-bit value written to them. Any other address reads zero.
- R3: With a nonzero configuration whose low 16 bits hold D, a tick occurs on every (D+1)-th `slow_en` pulse. A tick adds one to the seconds counter and sets status bit 1 in the same cycle. Any write to the configuration restarts the prescaler and its trim phase from zero.
- R4: When the configuration word is zero, a tick occurs on every 32768th `slow_en` pulse.
- R5: Bits 31:16 of the configuration are a signed two's-complement trim T. Every 1024th second lasts D+1+T pulses, with a minimum of one pulse. All other seconds last D+1 pulses. With T equal to zero, every second lasts D+1 pulses.
- R6: Status bit 0 (alarm flag) sets when a tick advances the seconds counter to a value equal to the alarm register. The counter wraps from 0xFFFFFFFF to 0.
- R7: Writing a 1 to status bit 0 or bit 1 clears that flag, and writing 0 there leaves it unchanged. Status bits 2 (alarm enable) and 3 (tick enable) are plain read/write bits.
- R8: `irq_alarm` is status bit 0 gated by bit 2, and `irq_tick` is bit 1 gated by bit 3. The flags set whether or not they are enabled.
- R9: If a flag is set by hardware and cleared by a write in the same cycle, the flag ends up set.
- R10: A software write to the seconds counter in the same cycle as a tick takes the written value, not the incremented one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_en | input | 1 | One-cycle pulse per slow oscillator period |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_tick | output | 1 | Once-per-second interrupt |

## Verification
The in-line assertions check the following on every cycle:
- a prescaler wrap returns its count to zero;
- the trim phase steps once per second;
- each tick moves the seconds counter up by exactly one unless software overwrites it;
- a hardware set always leaves its flag high;
- a flag stays set until a one is written to it.

Other behaviours need the bench's scenarios:
- the exact length of a second for a given divide value;
- the 32768-pulse fallback;
- the one trimmed second in every 1024;
- the alarm at the counter wrap;
- the interrupt gating seen from the ports.

// File: rtl/srtc_pkg.sv
package srtc_pkg;

    // Register selected by a bus address
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ALARM,
        SEL_COUNT,
        SEL_CONFIG,
        SEL_STATUS
    } reg_sel_e;

    // Status layout: each enable sits two bits above its flag
    typedef struct packed {
        logic tick_en;    // bit 3
        logic alarm_en;   // bit 2
        logic tick_flag;  // bit 1
        logic alarm_flag; // bit 0
    } status_t;

    localparam int ENABLE_SHIFT = 2;

    function automatic reg_sel_e decode_addr(input logic [4:0] addr, input bit alt_map);
        reg_sel_e sel;
        sel = SEL_NONE;
        if (!alt_map) begin
            case (addr)
                5'h00:   sel = SEL_ALARM;
                5'h04:   sel = SEL_COUNT;
                5'h08:   sel = SEL_CONFIG;
                5'h10:   sel = SEL_STATUS;
                default: sel = SEL_NONE;
            endcase
        end else begin
            case (addr)
                5'h00:   sel = SEL_COUNT;
                5'h04:   sel = SEL_ALARM;
                5'h08:   sel = SEL_STATUS;
                5'h0C:   sel = SEL_CONFIG;
                default: sel = SEL_NONE;
            endcase
        end
        return sel;
    endfunction

endpackage

// File: rtl/srtc_prescaler.sv
module srtc_prescaler #(
    parameter int DIV_W       = 16,
    parameter int TRIM_W      = 16,
    parameter int DEF_DIV     = 32767,
    parameter int TRIM_PERIOD = 1024
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      slow_en,
    input  logic                      restart,
    input  logic [DIV_W+TRIM_W-1:0]   cfg,
    output logic                      tick
);
    localparam int CNT_W = DIV_W + 2;
    localparam int PH_W  = $clog2(TRIM_PERIOD);

    logic [CNT_W-1:0]        cnt;
    logic [PH_W-1:0]         phase;
    logic [DIV_W-1:0]        base;
    logic [TRIM_W-1:0]       trim;
    logic                    trim_now;
    logic signed [CNT_W:0]   sum;
    logic [CNT_W-1:0]        term;

    assign base     = (cfg == '0) ? DEF_DIV[DIV_W-1:0] : cfg[DIV_W-1:0];
    assign trim     = cfg[DIV_W+TRIM_W-1:DIV_W];
    assign trim_now = (phase == PH_W'(TRIM_PERIOD - 1));

    always_comb begin
        sum = $signed({{(CNT_W+1-DIV_W){1'b0}}, base});
        if (trim_now)
            sum = sum + $signed({{(CNT_W+1-TRIM_W){trim[TRIM_W-1]}}, trim});
        term = (sum <= 0) ? '0 : sum[CNT_W-1:0];
    end

    assign tick = slow_en && (cnt >= term);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt   <= '0;
            phase <= '0;
        end else if (slow_en) begin
            if (tick) begin
                cnt   <= '0;
                phase <= trim_now ? '0 : phase + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0)) else $error("prescaler did not clear on wrap"); // R3

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart && !trim_now) |=> (phase == $past(phase) + 1'b1))
        else $error("trim phase did not advance"); // R5

endmodule

// File: rtl/srtc_status.sv
module srtc_status
    import srtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        alarm_set,
    input  logic        tick_set,
    input  logic        wr_en,
    input  logic [3:0]  wdata,
    output status_t     status,
    output logic        irq_alarm,
    output logic        irq_tick
);
    status_t wbits;
    logic [1:0] gated;

    assign wbits = status_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status.alarm_flag <= alarm_set |
                (status.alarm_flag & ~(wr_en & wbits.alarm_flag));
            status.tick_flag  <= tick_set |
                (status.tick_flag & ~(wr_en & wbits.tick_flag));
            if (wr_en) begin
                status.alarm_en <= wbits.alarm_en;
                status.tick_en  <= wbits.tick_en;
            end
        end
    end

    // Enables shifted down onto their flags select the live requests
    assign gated     = 2'(status >> ENABLE_SHIFT) & status[1:0];
    assign irq_alarm = gated[0];
    assign irq_tick  = gated[1];

    AST_TICK_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        tick_set |=> status.tick_flag) else $error("tick flag lost"); // R9

    AST_ALARM_SET: assert property (@(posedge clk) disable iff (rst)
        alarm_set |=> status.alarm_flag) else $error("alarm flag lost"); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status.alarm_flag && !(wr_en && wbits.alarm_flag)) |=> status.alarm_flag)
        else $error("alarm flag dropped without clear"); // R7

endmodule

// File: rtl/srtc_top.sv
module srtc_top
    import srtc_pkg::*;
#(
    parameter int  DATA_W      = 32,
    parameter int  DIV_W       = 16,
    parameter int  DEF_DIV     = 32767,
    parameter int  TRIM_PERIOD = 1024,
    parameter bit  ALT_MAP     = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slow_en,
    input  logic               bus_en,
    input  logic               bus_wr,
    input  logic [4:0]         bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_alarm,
    output logic               irq_tick
);
    localparam int TRIM_W = DATA_W - DIV_W;

    logic [DATA_W-1:0] seconds;
    logic [DATA_W-1:0] alarm_val;
    logic [DATA_W-1:0] cfg;
    logic [DATA_W-1:0] sec_next;
    reg_sel_e          sel;
    logic              wr_cnt, wr_alarm, wr_cfg, wr_stat;
    logic              tick;
    logic              alarm_hit;
    status_t           status;

    assign sel      = decode_addr(bus_addr, ALT_MAP);
    assign wr_cnt   = bus_en && bus_wr && (sel == SEL_COUNT);
    assign wr_alarm = bus_en && bus_wr && (sel == SEL_ALARM);
    assign wr_cfg   = bus_en && bus_wr && (sel == SEL_CONFIG);
    assign wr_stat  = bus_en && bus_wr && (sel == SEL_STATUS);

    srtc_prescaler #(
        .DIV_W       (DIV_W),
        .TRIM_W      (TRIM_W),
        .DEF_DIV     (DEF_DIV),
        .TRIM_PERIOD (TRIM_PERIOD)
    ) u_prescaler (
        .clk     (clk),
        .rst     (rst),
        .slow_en (slow_en),
        .restart (wr_cfg),
        .cfg     (cfg),
        .tick    (tick)
    );

    assign sec_next  = seconds + 1'b1;
    assign alarm_hit = tick && !wr_cnt && (sec_next == alarm_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            seconds   <= '0;
            alarm_val <= '0;
            cfg       <= '0;
        end else begin
            if (wr_cnt)
                seconds <= bus_wdata;
            else if (tick)
                seconds <= sec_next;
            if (wr_alarm)
                alarm_val <= bus_wdata;
            if (wr_cfg)
                cfg <= bus_wdata;
        end
    end

    srtc_status u_status (
        .clk       (clk),
        .rst       (rst),
        .alarm_set (alarm_hit),
        .tick_set  (tick),
        .wr_en     (wr_stat),
        .wdata     (bus_wdata[3:0]),
        .status    (status),
        .irq_alarm (irq_alarm),
        .irq_tick  (irq_tick)
    );

    always_comb begin
        case (sel)
            SEL_ALARM:  bus_rdata = alarm_val;
            SEL_COUNT:  bus_rdata = seconds;
            SEL_CONFIG: bus_rdata = cfg;
            SEL_STATUS: bus_rdata = {{(DATA_W-4){1'b0}}, status};
            default:    bus_rdata = '0;
        endcase
    end

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_cnt) |=> (seconds == $past(seconds) + 1'b1))
        else $error("seconds did not advance by one"); // R3

    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_cnt) |=> $stable(seconds))
        else $error("seconds moved without tick"); // R3

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (seconds == $past(bus_wdata)))
        else $error("counter write lost"); // R10

endmodule

// File: tb/srtc_top_tb_top.sv
module srtc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        slow_en;
    logic        bus_en;
    logic        bus_wr;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_alarm;
    logic        irq_tick;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    localparam logic [4:0] A_ALARM = 5'h00;
    localparam logic [4:0] A_COUNT = 5'h04;
    localparam logic [4:0] A_CFG   = 5'h08;
    localparam logic [4:0] A_STAT  = 5'h10;

    always #2.5 clk = ~clk;

    srtc_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .slow_en   (slow_en),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_alarm (irq_alarm),
        .irq_tick  (irq_tick)
    );

    // Vector: {write, addr, data, expected read}
    localparam int NVEC = 11;
    localparam logic [69:0] VEC [NVEC] = '{
        {1'b1, A_ALARM, 32'hDEAD_BEEF, 32'h0},
        {1'b1, A_COUNT, 32'h1234_5678, 32'h0},
        {1'b1, A_CFG,   32'hFFF0_0007, 32'h0},
        {1'b0, A_ALARM, 32'h0,         32'hDEAD_BEEF},
        {1'b0, A_COUNT, 32'h0,         32'h1234_5678},
        {1'b0, A_CFG,   32'h0,         32'hFFF0_0007},
        {1'b1, A_STAT,  32'h0000_000C, 32'h0},
        {1'b0, A_STAT,  32'h0,         32'h0000_000C},
        {1'b1, A_STAT,  32'h0,         32'h0},
        {1'b0, A_STAT,  32'h0,         32'h0},
        {1'b0, 5'h14,   32'h0,         32'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        slow_en = 1'b1;
        repeat (n) @(negedge clk);
        slow_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; slow_en = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_ALARM, v); check("R1 alarm", v, 32'h0);
        rd(A_COUNT, v); check("R1 count", v, 32'h0);
        rd(A_CFG, v);   check("R1 config", v, 32'h0);
        rd(A_STAT, v);  check("R1 status", v, 32'h0);
        check("R1 irqs", {30'h0, irq_alarm, irq_tick}, 32'h0);

        // R2 / R7 register table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][69]) wr(VEC[i][68:64], VEC[i][63:32]);
            else begin
                @(negedge clk);
                rd(VEC[i][68:64], v);
                check("R2 R7 table", v, VEC[i][31:0]);
            end
        end

        // R3 / R6 / R8 alarm with D=1
        wr(A_CFG, 32'h1);
        wr(A_COUNT, 32'd3);
        wr(A_ALARM, 32'd5);
        wr(A_STAT, 32'h3);
        run(3);
        @(negedge clk);
        rd(A_COUNT, v); check("R3 one tick per two pulses", v, 32'd4);
        rd(A_STAT, v);  check("R6 no alarm before match", v, 32'h2);
        run(1);
        @(negedge clk);
        rd(A_COUNT, v); check("R3 count", v, 32'd5);
        rd(A_STAT, v);  check("R6 R8 flags set without enable", v, 32'h3);
        check("R8 irqs masked", {30'h0, irq_alarm, irq_tick}, 32'h0);
        wr(A_STAT, 32'h4);
        rd(A_STAT, v);  check("R7 enable written, flags kept", v, 32'h7);
        check("R8 irq_alarm", {30'h0, irq_alarm, irq_tick}, 32'h2);
        wr(A_STAT, 32'h5);
        rd(A_STAT, v);  check("R7 w1c alarm", v, 32'h6);
        check("R8 irq_alarm low after clear", {31'h0, irq_alarm}, 32'h0);
        wr(A_STAT, 32'h8);
        rd(A_STAT, v);  check("R7 zero leaves flag", v, 32'hA);
        check("R8 irq_tick", {30'h0, irq_alarm, irq_tick}, 32'h1);

        // R6 wrap to zero hits alarm 0
        wr(A_STAT, 32'h3);
        wr(A_COUNT, 32'hFFFF_FFFF);
        wr(A_ALARM, 32'h0);
        wr(A_CFG, 32'h1);
        run(2);
        @(negedge clk);
        rd(A_COUNT, v); check("R6 wrap", v, 32'h0);
        rd(A_STAT, v);  check("R6 alarm at wrap", v, 32'h3);

        // R9 set wins over clear
        wr(A_CFG, 32'h1);
        wr(A_STAT, 32'h3);
        @(negedge clk); slow_en = 1'b1;
        @(negedge clk); bus_en = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h2;
        @(negedge clk); bus_en = 1'b0; bus_wr = 1'b0; slow_en = 1'b0;
        rd(A_STAT, v);  check("R9 tick flag survives clear", v & 32'h2, 32'h2);

        // R10 counter write wins over tick
        wr(A_CFG, 32'h1);
        @(negedge clk); slow_en = 1'b1;
        @(negedge clk); bus_en = 1'b1; bus_wr = 1'b1; bus_addr = A_COUNT; bus_wdata = 32'd100;
        @(negedge clk); bus_en = 1'b0; bus_wr = 1'b0; slow_en = 1'b0;
        rd(A_COUNT, v); check("R10 write beats tick", v, 32'd100);

        // R4 zero config divides by 32768
        wr(A_CFG, 32'h0);
        wr(A_COUNT, 32'h0);
        run(32767);
        @(negedge clk);
        rd(A_COUNT, v); check("R4 no tick at 32767", v, 32'h0);
        run(1);
        @(negedge clk);
        rd(A_COUNT, v); check("R4 tick at 32768", v, 32'h1);

        // R5 trim zero: 2048 pulses give 1024 seconds
        wr(A_CFG, 32'h1);
        wr(A_COUNT, 32'h0);
        run(2048);
        @(negedge clk);
        rd(A_COUNT, v); check("R5 zero trim", v, 32'd1024);

        // R5 positive trim +3 on D=1
        wr(A_CFG, 32'h0003_0001);
        wr(A_COUNT, 32'h0);
        run(2050);
        @(negedge clk);
        rd(A_COUNT, v); check("R5 long second pending", v, 32'd1023);
        run(1);
        @(negedge clk);
        rd(A_COUNT, v); check("R5 long second done", v, 32'd1024);
        run(2);
        @(negedge clk);
        rd(A_COUNT, v); check("R5 normal after trim", v, 32'd1025);

        // R5 negative trim -2 on D=3
        wr(A_CFG, 32'hFFFE_0003);
        wr(A_COUNT, 32'h0);
        run(4093);
        @(negedge clk);
        rd(A_COUNT, v); check("R5 short second pending", v, 32'd1023);
        run(1);
        @(negedge clk);
        rd(A_COUNT, v); check("R5 short second done", v, 32'd1024);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule